// File: doc/BRIEF.md
# Inbound Message-Signalled Interrupt Capture Controller

This block sits beside the inbound write path of a PCIe root port and turns message-signalled interrupt writes into interrupt status. Every inbound write is compared against a programmable 64-bit target address. On a match, the low eight data bits name one of 256 vectors, which are grouped as eight banks of 32. The vector's status bit is set if that vector is enabled. Writes that do not match leave the block unchanged on a bypass output.

Each bank has three 32-bit registers: enable, mask and status. Status is cleared by writing ones. A simple 32-bit register port reaches these registers and the two halves of the target address. The block drives one registered interrupt line. This line is high whenever any status bit in any bank is set while its mask bit is clear.

Top module: `msi_irq_ctrl`

## Requirements
- R1: After reset: all enables are 0, all masks are all ones, all status bits are 0, both target address halves are 0, `irq` is 0 and `reg_rdata` is 0.
- R2: The low half of the target address is read and written at offset 0x820. The high half is at offset 0x824.
- R3: Bank b (0..7) has its enable register at 0x828+12*b, its mask register at 0x82C+12*b and its status register at 0x830+12*b. Enable and mask read back the last value written.
- R4: An inbound write sets status bit v[4:0] of bank v[7:5] when `msi_valid` is 1, `msi_addr` equals {high half, low half} and that vector's enable bit is 1. Here v = `msi_data[7:0]`, and data bits 31:8 are ignored.
- R5: A matching inbound write to a vector whose enable bit is 0 is dropped, and the status stays unchanged.
- R6: Writing a status register clears the bits written as 1 and leaves the bits written as 0. A register write never sets a status bit.
- R7: When an inbound set and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R8: `irq` is a registered OR of (status AND NOT mask) over all banks. It changes at the same clock edge as the state that drives it. A pending bit that is masked stays set and raises `irq` once its mask bit is cleared.
- R9: A valid inbound write that does not match appears on `byp_valid`/`byp_addr`/`byp_data` in the same cycle and changes no interrupt state. A matching write leaves `byp_valid` at 0.
- R10: Read data appears on `reg_rdata` one cycle after the read. Offsets not listed in R2/R3, including unaligned ones, read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_valid | input | 1 | Inbound write valid |
| msi_addr | input | 64 | Inbound write address |
| msi_data | input | 32 | Inbound write data |
| byp_valid | output | 1 | Non-matching inbound write valid |
| byp_addr | output | 64 | Bypassed write address |
| byp_data | output | 32 | Bypassed write data |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the read |
| irq | output | 1 | Combined interrupt |

## Verification
Register writes and inbound captures take effect at the first rising edge after they are presented. `irq` reflects that same edge. Read data is valid after the edge that follows the read strobe, and the bypass outputs follow the inbound inputs within the same cycle. The bench drives on falling edges and checks `irq` at the next falling edge. It checks the bypass outputs one nanosecond after driving them. Reads push their expected value into a queue, and a monitor pops and compares that value at the falling edge after the sampling edge.

// File: rtl/msi_irq_pkg.sv
package msi_irq_pkg;

    localparam int REG_DW       = 32;
    localparam int MATCH_W      = 2 * REG_DW;
    localparam int OFF_MATCH_LO = 'h820;
    localparam int OFF_MATCH_HI = 'h824;
    localparam int OFF_BANK0    = 'h828;
    localparam int BANK_STRIDE  = 12;
    localparam int SUB_EN       = 0;
    localparam int SUB_MASK     = 4;
    localparam int SUB_STAT     = 8;

    typedef struct packed {
        logic [REG_DW-1:0] hi;
        logic [REG_DW-1:0] lo;
    } match_st_t;

    typedef struct packed {
        logic [REG_DW-1:0] en;
        logic [REG_DW-1:0] mask;
        logic [REG_DW-1:0] stat;
    } bank_st_t;

    typedef struct packed {
        logic [REG_DW-1:0] rdata;
        logic              irq;
    } top_st_t;

    function automatic int bank_off(int b, int sub);
        return OFF_BANK0 + b * BANK_STRIDE + sub;
    endfunction

endpackage

// File: rtl/msi_addr_match.sv
module msi_addr_match
    import msi_irq_pkg::*;
#(
    parameter int IN_DW = 32,
    parameter int VEC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [REG_DW-1:0]  wdata,
    input  logic               in_valid,
    input  logic [MATCH_W-1:0] in_addr,
    input  logic [IN_DW-1:0]   in_data,
    output logic [REG_DW-1:0]  match_lo,
    output logic [REG_DW-1:0]  match_hi,
    output logic               hit,
    output logic [VEC_W-1:0]   vec,
    output logic               byp_valid,
    output logic [MATCH_W-1:0] byp_addr,
    output logic [IN_DW-1:0]   byp_data
);

    match_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_lo) st_d.lo = wdata;
        if (wr_hi) st_d.hi = wdata;
        hit       = in_valid && (in_addr == {st_q.hi, st_q.lo});
        vec       = in_data[VEC_W-1:0];
        byp_valid = in_valid && !hit;
        byp_addr  = in_addr;
        byp_data  = in_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign match_lo = st_q.lo;
    assign match_hi = st_q.hi;

    // R2: written halves hold the written word on the next cycle
    a_r2_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (match_lo == $past(wdata)));
    a_r2_hi_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (match_hi == $past(wdata)));

endmodule

// File: rtl/msi_vec_bank.sv
module msi_vec_bank
    import msi_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_mask,
    input  logic              wr_stat,
    input  logic [REG_DW-1:0] wdata,
    input  logic [REG_DW-1:0] set_req,
    output logic [REG_DW-1:0] en,
    output logic [REG_DW-1:0] mask,
    output logic [REG_DW-1:0] stat,
    output logic [REG_DW-1:0] pend_nxt
);

    bank_st_t          st_d, st_q;
    logic [REG_DW-1:0] set_hit;
    logic [REG_DW-1:0] clr_bits;

    always_comb begin
        st_d     = st_q;
        set_hit  = set_req & st_q.en;
        clr_bits = wr_stat ? wdata : '0;
        if (wr_en)   st_d.en   = wdata;
        if (wr_mask) st_d.mask = wdata;
        // a capture in the same cycle overrides a clear
        st_d.stat = (st_q.stat & ~clr_bits) | set_hit;
        pend_nxt  = st_d.stat & ~st_d.mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.en   <= '0;
            st_q.mask <= '1;
            st_q.stat <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en   = st_q.en;
    assign mask = st_q.mask;
    assign stat = st_q.stat;

    // R5: no status bit appears unless an enabled capture asked for it
    a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat & ~$past(stat) & ~$past(set_hit)) == '0));
    // R6: cleared bits are gone unless captured in the same cycle
    a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> ((stat & $past(wdata & ~set_hit)) == '0));
    // R7: captured bits are always present afterwards
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_hit != '0) |=> ((stat & $past(set_hit)) == $past(set_hit)));

endmodule

// File: rtl/msi_irq_ctrl.sv
module msi_irq_ctrl
    import msi_irq_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int REG_AW    = 12,
    parameter int IN_DW     = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               msi_valid,
    input  logic [MATCH_W-1:0] msi_addr,
    input  logic [IN_DW-1:0]   msi_data,
    output logic               byp_valid,
    output logic [MATCH_W-1:0] byp_addr,
    output logic [IN_DW-1:0]   byp_data,
    input  logic               reg_en,
    input  logic               reg_we,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [REG_DW-1:0]  reg_wdata,
    output logic [REG_DW-1:0]  reg_rdata,
    output logic               irq
);

    localparam int NUM_VEC = NUM_BANKS * REG_DW;
    localparam int VEC_W   = $clog2(NUM_VEC);
    localparam int BIDX_W  = $clog2(REG_DW);
    localparam int BSEL_W  = VEC_W - BIDX_W;
    localparam int FLAT_W  = NUM_BANKS * REG_DW;

    logic wr_stb, rd_stb;
    logic wr_lo, wr_hi;
    logic hit;
    logic [VEC_W-1:0]  vec;
    logic [REG_DW-1:0] match_lo, match_hi;
    logic [FLAT_W-1:0] en_flat, mask_flat, stat_flat, pend_nxt_flat, set_flat;
    logic [NUM_BANKS-1:0] sel_stat;
    logic [REG_DW-1:0] rd_val;
    top_st_t st_d, st_q;

    assign wr_stb = reg_en && reg_we;
    assign rd_stb = reg_en && !reg_we;
    assign wr_lo  = wr_stb && (reg_addr == REG_AW'(OFF_MATCH_LO));
    assign wr_hi  = wr_stb && (reg_addr == REG_AW'(OFF_MATCH_HI));

    msi_addr_match #(.IN_DW(IN_DW), .VEC_W(VEC_W)) match_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .wdata     (reg_wdata),
        .in_valid  (msi_valid),
        .in_addr   (msi_addr),
        .in_data   (msi_data),
        .match_lo  (match_lo),
        .match_hi  (match_hi),
        .hit       (hit),
        .vec       (vec),
        .byp_valid (byp_valid),
        .byp_addr  (byp_addr),
        .byp_data  (byp_data)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel_en, sel_mask;
        logic [REG_DW-1:0] set_one;

        assign sel_en      = wr_stb && (reg_addr == REG_AW'(bank_off(b, SUB_EN)));
        assign sel_mask    = wr_stb && (reg_addr == REG_AW'(bank_off(b, SUB_MASK)));
        assign sel_stat[b] = wr_stb && (reg_addr == REG_AW'(bank_off(b, SUB_STAT)));
        assign set_one     = (hit && (vec[VEC_W-1:BIDX_W] == BSEL_W'(b)))
                             ? (REG_DW'(1) << vec[BIDX_W-1:0]) : '0;
        assign set_flat[b*REG_DW +: REG_DW] = set_one;

        msi_vec_bank bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (sel_en),
            .wr_mask  (sel_mask),
            .wr_stat  (sel_stat[b]),
            .wdata    (reg_wdata),
            .set_req  (set_one),
            .en       (en_flat[b*REG_DW +: REG_DW]),
            .mask     (mask_flat[b*REG_DW +: REG_DW]),
            .stat     (stat_flat[b*REG_DW +: REG_DW]),
            .pend_nxt (pend_nxt_flat[b*REG_DW +: REG_DW])
        );
    end

    always_comb begin
        rd_val = '0;
        if (reg_addr == REG_AW'(OFF_MATCH_LO)) rd_val = match_lo;
        if (reg_addr == REG_AW'(OFF_MATCH_HI)) rd_val = match_hi;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (reg_addr == REG_AW'(bank_off(b, SUB_EN)))   rd_val = en_flat[b*REG_DW +: REG_DW];
            if (reg_addr == REG_AW'(bank_off(b, SUB_MASK))) rd_val = mask_flat[b*REG_DW +: REG_DW];
            if (reg_addr == REG_AW'(bank_off(b, SUB_STAT))) rd_val = stat_flat[b*REG_DW +: REG_DW];
        end
        st_d.rdata = rd_stb ? rd_val : '0;
        st_d.irq   = |pend_nxt_flat;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;
    assign irq       = st_q.irq;

    // R8: the line tracks deliverable pending state of the same cycle
    a_r8_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(stat_flat & ~mask_flat));
    // R9: a bypassed write leaves interrupt status untouched
    a_r9_byp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (byp_valid && (sel_stat == '0)) |=> (stat_flat == $past(stat_flat)));

endmodule

// File: tb/msi_irq_ctrl_tb_top.sv
module msi_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        msi_valid;
    logic [63:0] msi_addr;
    logic [31:0] msi_data;
    logic        byp_valid;
    logic [63:0] byp_addr;
    logic [31:0] byp_data;
    logic        reg_en, reg_we;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        irq;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;
    logic        rd_pend = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] mon_exp;
    string       mon_tag;

    localparam logic [63:0] HIT_ADDR = 64'h00000001_01FF8000;

    always #2 clk = ~clk;

    msi_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .msi_valid(msi_valid), .msi_addr(msi_addr), .msi_data(msi_data),
        .byp_valid(byp_valid), .byp_addr(byp_addr), .byp_data(byp_data),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares read data one cycle after each read
    always @(posedge clk) rd_pend <= reg_en && !reg_we;
    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected read", 64'(reg_rdata), 64'hDEAD);
            end else begin
                mon_exp = exp_q.pop_front();
                mon_tag = tag_q.pop_front();
                check(mon_tag, 64'(reg_rdata), 64'(mon_exp));
            end
        end
    end

    task automatic wr(logic [11:0] a, logic [31:0] d);
        reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 0; reg_we = 0;
    endtask

    task automatic rd(logic [11:0] a, logic [31:0] e, string tag);
        reg_en = 1; reg_we = 0; reg_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        reg_en = 0;
    endtask

    task automatic msi(logic [63:0] a, logic [31:0] d, bit match, string tag);
        msi_valid = 1; msi_addr = a; msi_data = d;
        #1;
        check({tag, " R9 byp_valid"}, 64'(byp_valid), 64'(!match));
        if (!match) begin
            check("R9 byp_addr", byp_addr, a);
            check("R9 byp_data", 64'(byp_data), 64'(d));
        end
        @(negedge clk);
        msi_valid = 0;
    endtask

    task automatic chk_irq(logic e, string tag);
        check(tag, 64'(irq), 64'(e));
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; bad++;
            $display("FAIL watchdog: got hung run expected completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 0; msi_valid = 0; msi_addr = '0; msi_data = '0;
        reg_en = 0; reg_we = 0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk_irq(1'b0, "R1 irq after reset");
        check("R1 byp_valid idle", 64'(byp_valid), 64'd0);
        check("R1 rdata after reset", 64'(reg_rdata), 64'd0);
        rd(12'h820, 32'h0, "R1 match low reset");
        rd(12'h82C, 32'hFFFFFFFF, "R1 bank0 mask reset");
        rd(12'h87C, 32'h0, "R1 bank7 enable reset");
        rd(12'h854, 32'h0, "R1 bank3 status reset");

        // R2 target address
        wr(12'h820, 32'h01FF8000);
        wr(12'h824, 32'h00000001);
        rd(12'h820, 32'h01FF8000, "R2 match low");
        rd(12'h824, 32'h00000001, "R2 match high");

        // R3 bank layout
        wr(12'h828, 32'h00000021);
        wr(12'h82C, 32'h00000000);
        wr(12'h87C, 32'h80000000);
        wr(12'h880, 32'h80000000);
        rd(12'h828, 32'h00000021, "R3 bank0 enable");
        rd(12'h82C, 32'h00000000, "R3 bank0 mask");
        rd(12'h87C, 32'h80000000, "R3 bank7 enable");
        chk_irq(1'b0, "R8 nothing pending");

        // R4 capture, upper data bits ignored
        msi(HIT_ADDR, 32'h5A5AAB05, 1'b1, "R4 vec5");
        chk_irq(1'b1, "R4 R8 irq after vec5");
        rd(12'h830, 32'h00000020, "R4 bank0 status bit5");

        // R5 disabled vector dropped
        msi(HIT_ADDR, 32'h00000006, 1'b1, "R5 vec6");
        rd(12'h830, 32'h00000020, "R5 disabled vec6 dropped");

        // R6 write-1-to-clear
        wr(12'h830, 32'h00000001);
        rd(12'h830, 32'h00000020, "R6 clear of idle bit sets nothing");
        wr(12'h830, 32'hFFFFFFFF);
        chk_irq(1'b0, "R6 irq after clear");
        rd(12'h830, 32'h00000000, "R6 status cleared");

        // R8 masked pending, then unmasked
        msi(HIT_ADDR, 32'h000012FF, 1'b1, "R8 vec255");
        chk_irq(1'b0, "R8 masked vec255 no irq");
        rd(12'h884, 32'h80000000, "R8 masked bit stays pending");
        wr(12'h880, 32'h00000000);
        chk_irq(1'b1, "R8 irq on unmask");
        wr(12'h884, 32'h80000000);
        chk_irq(1'b0, "R8 irq drops after clear");

        // R7 same-cycle set and clear on vec0
        msi_valid = 1; msi_addr = HIT_ADDR; msi_data = 32'h0;
        reg_en = 1; reg_we = 1; reg_addr = 12'h830; reg_wdata = 32'h1;
        @(negedge clk);
        msi_valid = 0; reg_en = 0; reg_we = 0;
        chk_irq(1'b1, "R7 irq after collision");
        rd(12'h830, 32'h00000001, "R7 set wins over clear");
        wr(12'h830, 32'h00000001);
        chk_irq(1'b0, "R7 irq after later clear");

        // R9 non-matching write bypassed
        msi(64'h00000000_01FF8000, 32'h00000005, 1'b0, "R9 miss");
        chk_irq(1'b0, "R9 irq after miss");
        rd(12'h830, 32'h00000000, "R9 status untouched by miss");

        // R10 unused offsets
        wr(12'h888, 32'hFFFFFFFF);
        chk_irq(1'b0, "R10 irq after unused write");
        rd(12'h888, 32'h0, "R10 unused 0x888 reads 0");
        rd(12'h82A, 32'h0, "R10 unaligned reads 0");
        rd(12'h900, 32'h0, "R10 unused 0x900 reads 0");
        rd(12'h828, 32'h00000021, "R10 unused write left bank0");

        repeat (3) @(negedge clk);
        check("R10 all reads answered", 64'(exp_q.size()), 64'd0);
        finish_run();
    end

endmodule